// File: doc/BRIEF.md
# Scan Level-Shifter Gate-Shading Controller

This block sequences the digital side of a panel scan level shifter. It handles seven channels: one start-pulse channel and a parameterised set of clock channels, six by default. Outside a shading window, every output drives the synchronised level of its logic input. When shading is enabled, a falling clock edge opens a one-shot shading window. During the window, each clock channel whose input is low stops driving (high impedance) and closes its discharge switch. A channel whose input is high keeps driving high.

The window length is set by an external RC timing node. The block sees that node only through two comparator flags: `tmr_hi` (the node is above the upper threshold) and `tmr_lo` (the node is below the lower threshold). The block drives the switch that shorts the timing capacitor. That switch opens to start a window and closes when the upper flag is seen. A new window can open only after the node has fallen below the lower threshold again.

Clock channels with odd channel numbers (1, 3, 5) share one discharge node, and even channel numbers (2, 4, 6) share the other. The block reports when each node is in use. All logic inputs and both comparator flags pass through a synchroniser before they are used.

Top module: `scan_shade_ctrl`

## Requirements
- R1: `start_val` equals `start_in` delayed by SYNC_STAGES clock edges, and `start_oe` is 1 whenever `chip_en` is 1.
- R2: Outside a shading window, every clock channel drives its input: `ck_oe` bit i is 1 and `ck_val` bit i equals `ck_in` bit i delayed by SYNC_STAGES edges.
- R3: A window opens only when all of these hold: the controller is armed, shading is enabled, the synchronised lower flag is 1, and a synchronised falling edge appears on any clock input. The window takes effect one edge after the edge is seen, which is SYNC_STAGES+1 edges after the input change.
- R4: `tmr_short` is 0 throughout a window and 1 at all other times, including after reset.
- R5: A window closes on the edge after the synchronised upper flag is seen. From then on, all outputs follow their inputs again.
- R6: During a window, a clock channel whose input is low has `ck_oe`=0 and its `dis_sw` bit =1. A channel whose input is high has `ck_oe`=1, `ck_val`=1 and `dis_sw`=0. A channel never drives while its switch is closed.
- R7: Bit i of the clock vectors is channel i+1. `odd_busy` is 1 exactly when a switch on bits 0, 2 or 4 is closed. `even_busy` is 1 exactly when a switch on bits 1, 3 or 5 is closed.
- R8: Falling edges open no window in either of two cases: after a window has closed, until the synchronised lower flag has been seen again; or while the lower flag is 0.
- R9: With `shade_en`=0, no window opens: `tmr_short` stays 1 and clock outputs keep following their inputs.
- R10: With `chip_en`=0, every output enable and every discharge switch is 0. A window that is open closes on the next edge and waits for the lower flag before it re-arms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Enables all level-shifter outputs |
| shade_en | input | 1 | Gate shading enabled (timing resistor fitted) |
| start_in | input | 1 | Start-pulse logic input |
| ck_in | input | NUM_CK | Clock logic inputs, bit 0 = channel 1 |
| tmr_hi | input | 1 | Timing node above upper threshold |
| tmr_lo | input | 1 | Timing node below lower threshold |
| start_oe | output | 1 | Start output drive enable |
| start_val | output | 1 | Start output level |
| ck_oe | output | NUM_CK | Clock output drive enables |
| ck_val | output | NUM_CK | Clock output levels |
| dis_sw | output | NUM_CK | Per-channel discharge switch closed |
| odd_busy | output | 1 | Odd discharge node in use |
| even_busy | output | 1 | Even discharge node in use |
| tmr_short | output | 1 | Timing capacitor short switch closed |

## Verification
The bench builds the block with its defaults: six clock channels and a two-stage synchroniser. With these values the window opens exactly three edges after a falling input and closes three edges after the upper flag. This lets the bench check the last cycle of driving low just before a channel goes high impedance. Six channels cover both discharge groups with several members each, so the bench can show one group going idle while the other stays busy. It can also show channels entering and leaving the switched state while a window is open.

// File: rtl/scan_shade_pkg.sv
package scan_shade_pkg;

    typedef enum logic [1:0] {
        IDLE_ARMED = 2'd0,
        SHADING    = 2'd1,
        WAIT_REARM = 2'd2
    } shade_state_e;

    typedef struct packed {
        logic oe;
        logic val;
        logic sw;
    } chan_drive_t;

    // Mask of bits whose channel number (index + 1) is odd.
    function automatic logic [31:0] odd_chan_mask(input int n);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < n && i < 32; i++) begin
            if ((i % 2) == 0) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/scan_sync.sv
module scan_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
        end else begin
            pipe[0] <= d;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/shade_fsm.sv
module shade_fsm
    import scan_shade_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         chip_en,
    input  logic         shade_en,
    input  logic         fall_any,
    input  logic         hi_s,
    input  logic         lo_s,
    output shade_state_e state,
    output logic         shading
);
    shade_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            IDLE_ARMED: if (chip_en && shade_en && lo_s && fall_any) nxt = SHADING;
            SHADING:    if (hi_s || !chip_en || !shade_en)           nxt = WAIT_REARM;
            WAIT_REARM: if (lo_s)                                    nxt = IDLE_ARMED;
            default:                                                 nxt = WAIT_REARM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= IDLE_ARMED;
        else     state <= nxt;
    end

    assign shading = (state == SHADING);
endmodule

// File: rtl/scan_out_stage.sv
module scan_out_stage
    import scan_shade_pkg::*;
(
    input  logic        chip_en,
    input  logic        shading,
    input  logic        level,
    output chan_drive_t drv
);
    always_comb begin
        drv.val = level;
        drv.sw  = chip_en & shading & ~level;
        drv.oe  = chip_en & ~(shading & ~level);
    end
endmodule

// File: rtl/scan_shade_ctrl.sv
module scan_shade_ctrl
    import scan_shade_pkg::*;
#(
    parameter int NUM_CK      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              shade_en,
    input  logic              start_in,
    input  logic [NUM_CK-1:0] ck_in,
    input  logic              tmr_hi,
    input  logic              tmr_lo,
    output logic              start_oe,
    output logic              start_val,
    output logic [NUM_CK-1:0] ck_oe,
    output logic [NUM_CK-1:0] ck_val,
    output logic [NUM_CK-1:0] dis_sw,
    output logic              odd_busy,
    output logic              even_busy,
    output logic              tmr_short
);
    localparam int SW = NUM_CK + 3;
    localparam logic [NUM_CK-1:0] ODD_MASK = NUM_CK'(odd_chan_mask(NUM_CK));

    logic [SW-1:0]     sync_q;
    logic [NUM_CK-1:0] ck_s, ck_prev, ck_fall;
    logic              start_s, tmr_hi_s, tmr_lo_s, shading;
    shade_state_e      state;
    chan_drive_t       drv [NUM_CK];

    scan_sync #(.W(SW), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({tmr_hi, tmr_lo, start_in, ck_in}),
        .q   (sync_q)
    );

    assign ck_s     = sync_q[NUM_CK-1:0];
    assign start_s  = sync_q[NUM_CK];
    assign tmr_lo_s = sync_q[NUM_CK+1];
    assign tmr_hi_s = sync_q[NUM_CK+2];

    always_ff @(posedge clk) begin
        if (rst) ck_prev <= '0;
        else     ck_prev <= ck_s;
    end

    assign ck_fall = ck_prev & ~ck_s;

    shade_fsm fsm_i (
        .clk      (clk),
        .rst      (rst),
        .chip_en  (chip_en),
        .shade_en (shade_en),
        .fall_any (|ck_fall),
        .hi_s     (tmr_hi_s),
        .lo_s     (tmr_lo_s),
        .state    (state),
        .shading  (shading)
    );

    for (genvar g = 0; g < NUM_CK; g++) begin : g_chan
        scan_out_stage stage_i (
            .chip_en (chip_en),
            .shading (shading),
            .level   (ck_s[g]),
            .drv     (drv[g])
        );
        assign ck_oe[g]  = drv[g].oe;
        assign ck_val[g] = drv[g].val;
        assign dis_sw[g] = drv[g].sw;
    end

    assign start_oe  = chip_en;
    assign start_val = start_s;
    assign odd_busy  = |(dis_sw & ODD_MASK);
    assign even_busy = |(dis_sw & ~ODD_MASK);
    assign tmr_short = (state != SHADING);
endmodule

// File: rtl/scan_shade_chk.sv
module scan_shade_chk #(
    parameter int NUM_CK = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              chip_en,
    input logic              shade_en,
    input logic              tmr_hi_s,
    input logic              tmr_lo_s,
    input logic              tmr_short,
    input logic              start_oe,
    input logic [NUM_CK-1:0] ck_oe,
    input logic [NUM_CK-1:0] dis_sw,
    input logic              odd_busy,
    input logic              even_busy
);
    a_r3_open_needs_low_flag: assert property (@(posedge clk) disable iff (rst)
        $fell(tmr_short) |-> $past(tmr_lo_s));

    a_r9_open_needs_enables: assert property (@(posedge clk) disable iff (rst)
        $fell(tmr_short) |-> ($past(shade_en) && $past(chip_en)));

    a_r5_close_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(tmr_short) |-> ($past(tmr_hi_s) || !$past(shade_en) || !$past(chip_en)));

    a_r6_no_drive_into_switch: assert property (@(posedge clk) disable iff (rst)
        (ck_oe & dis_sw) == '0);

    a_r7_nodes_only_in_window: assert property (@(posedge clk) disable iff (rst)
        (odd_busy || even_busy) |-> !tmr_short);

    a_r10_disabled_all_off: assert property (@(posedge clk) disable iff (rst)
        !chip_en |-> (!start_oe && ck_oe == '0 && dis_sw == '0));
endmodule

bind scan_shade_ctrl scan_shade_chk #(.NUM_CK(NUM_CK)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .chip_en   (chip_en),
    .shade_en  (shade_en),
    .tmr_hi_s  (tmr_hi_s),
    .tmr_lo_s  (tmr_lo_s),
    .tmr_short (tmr_short),
    .start_oe  (start_oe),
    .ck_oe     (ck_oe),
    .dis_sw    (dis_sw),
    .odd_busy  (odd_busy),
    .even_busy (even_busy)
);

// File: tb/scan_shade_ctrl_tb_top.sv
module scan_shade_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCK = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           chip_en = 1'b1;
    logic           shade_en = 1'b1;
    logic           start_in = 1'b0;
    logic [NCK-1:0] ck_in = '0;
    logic           tmr_hi = 1'b0;
    logic           tmr_lo = 1'b1;
    logic           start_oe, start_val, odd_busy, even_busy, tmr_short;
    logic [NCK-1:0] ck_oe, ck_val, dis_sw;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_shade_ctrl #(.NUM_CK(NCK), .SYNC_STAGES(2)) dut_i (
        .clk (clk), .rst (rst), .chip_en (chip_en), .shade_en (shade_en),
        .start_in (start_in), .ck_in (ck_in), .tmr_hi (tmr_hi), .tmr_lo (tmr_lo),
        .start_oe (start_oe), .start_val (start_val), .ck_oe (ck_oe),
        .ck_val (ck_val), .dis_sw (dis_sw), .odd_busy (odd_busy),
        .even_busy (even_busy), .tmr_short (tmr_short)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        step(3);
        chk("R4 reset short closed", 32'(tmr_short), 32'd1);
        chk("R2 reset all driving", 32'(ck_oe), 32'h3F);
        chk("R6 reset switches open", 32'(dis_sw), 32'h0);
        chk("R1 reset start driven", 32'(start_oe), 32'd1);
    endtask

    task automatic t_follow;
        tmr_lo = 1'b0;
        step(3);
        ck_in = 6'b101010; start_in = 1'b1;
        step(2);
        chk("R2 follow pattern A", 32'(ck_val), 32'h2A);
        chk("R1 start follows", 32'(start_val), 32'd1);
        ck_in = 6'b010101; start_in = 1'b0;
        step(3);
        chk("R2 follow pattern B", 32'(ck_val), 32'h15);
        chk("R8 no window without low flag", 32'(tmr_short), 32'd1);
        chk("R2 all driving", 32'(ck_oe), 32'h3F);
        chk("R1 start low", 32'(start_val), 32'd0);
    endtask

    task automatic t_window;
        tmr_lo = 1'b1; ck_in = 6'b111111;
        step(3);
        ck_in = 6'b111100;
        step(2);
        chk("R3 last edge still driving", 32'(ck_oe), 32'h3F);
        chk("R3 short still closed", 32'(tmr_short), 32'd1);
        step(1);
        chk("R4 short opens", 32'(tmr_short), 32'd0);
        chk("R6 low channels high-Z", 32'(ck_oe), 32'h3C);
        chk("R6 low channels switched", 32'(dis_sw), 32'h03);
        chk("R6 high channels drive high", 32'(ck_val & ck_oe), 32'h3C);
        chk("R7 odd busy", 32'(odd_busy), 32'd1);
        chk("R7 even busy", 32'(even_busy), 32'd1);
        tmr_lo = 1'b0; ck_in = 6'b101100;
        step(2);
        chk("R6 channel 5 joins", 32'(dis_sw), 32'h13);
        ck_in = 6'b101110;
        step(2);
        chk("R6 channel 2 leaves", 32'(dis_sw), 32'h11);
        chk("R7 odd still busy", 32'(odd_busy), 32'd1);
        chk("R7 even idle", 32'(even_busy), 32'd0);
    endtask

    task automatic t_end_rearm;
        tmr_hi = 1'b1;
        step(2);
        chk("R5 window open until seen", 32'(tmr_short), 32'd0);
        step(1);
        chk("R5 short closes", 32'(tmr_short), 32'd1);
        chk("R5 outputs follow", 32'(ck_oe), 32'h3F);
        chk("R7 nodes idle", 32'({odd_busy, even_busy}), 32'd0);
        tmr_hi = 1'b0;
        ck_in = 6'b001110;
        step(3);
        chk("R8 no re-arm before low flag", 32'(tmr_short), 32'd1);
        chk("R8 all driving", 32'(ck_oe), 32'h3F);
        tmr_lo = 1'b1;
        step(3);
        ck_in = 6'b000110;
        step(3);
        chk("R8 re-armed window opens", 32'(tmr_short), 32'd0);
        chk("R6 all low channels switched", 32'(dis_sw), 32'h39);
        tmr_lo = 1'b0; tmr_hi = 1'b1;
        step(3);
        tmr_hi = 1'b0; tmr_lo = 1'b1;
        step(3);
    endtask

    task automatic t_shade_off;
        shade_en = 1'b0; ck_in = 6'b111111;
        step(3);
        ck_in = 6'b000000;
        step(3);
        chk("R9 no window when disabled", 32'(tmr_short), 32'd1);
        chk("R9 outputs follow low", 32'(ck_oe), 32'h3F);
        chk("R9 values low", 32'(ck_val), 32'h00);
        chk("R9 switches open", 32'(dis_sw), 32'h00);
        shade_en = 1'b1;
        step(1);
    endtask

    task automatic t_disable;
        ck_in = 6'b111111;
        step(3);
        ck_in = 6'b111110;
        step(3);
        chk("R3 window for abort test", 32'(tmr_short), 32'd0);
        chip_en = 1'b0;
        #1;
        chk("R10 start high-Z", 32'(start_oe), 32'd0);
        chk("R10 clocks high-Z", 32'(ck_oe), 32'h00);
        chk("R10 switches open", 32'(dis_sw), 32'h00);
        step(1);
        chk("R10 window aborted", 32'(tmr_short), 32'd1);
        chip_en = 1'b1;
        step(3);
        chk("R10 outputs back", 32'(ck_oe), 32'h3F);
        chk("R10 start back", 32'(start_oe), 32'd1);
    endtask

    initial begin
        t_reset();
        t_follow();
        t_window();
        t_end_rearm();
        t_shade_off();
        t_disable();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule